// File: doc/BRIEF.md
# SPI Master Descriptor-Chained Engine

This block is a single-master SPI controller whose work list lives in two small descriptor rings, one for transmit and one for receive, plus a shared byte buffer memory, all held inside the block. Software fills buffer bytes and descriptors through a write port, then writes a start command. From then on the engine runs without software help. It prefetches transmit bytes into a one-byte holding stage and shifts each character out on MOSI in SPI mode 0, MSB first, while sampling MISO. It files each received byte into the current receive buffer and closes descriptors as they finish. It also follows the last flag of each transmit descriptor, either chaining on to the next one or stopping.

Each descriptor word has the following fields: bit 31 ready (transmit) or empty (receive), bit 30 wrap, bit 29 last, bits 23:8 length in bytes, and bits 7:0 the base byte index into the buffer memory. Software registers sit in select space 0. Address 0 is the control word: bits 7:0 hold the clock divider, bits 10:8 the interrupt mask, and writing bit 31 issues a start. Address 1 is the status word: bit 0 is transmit buffer done, bit 1 is receive buffer closed and bit 2 is overrun, each cleared by writing 1, and bit 3 reads as busy. Select 1 addresses transmit descriptors, select 2 receive descriptors and select 3 buffer bytes. A read port with the same map returns data in the same cycle.

Top module: `spi_bd_master`

## Requirements
- R1: After reset, cs_n_o is high, sck_o and mosi_o are low, irq_o is low and the status word reads 0. SCK never pulses while cs_n_o is high.
- R2: A start with the current transmit descriptor ready asserts cs_n_o low. No SCK edge occurs before the first byte has been loaded from the buffer. Each character gives 8 SCK rising edges spaced 2*(div+1) clocks apart, with MOSI stable while SCK is high and MSB first.
- R3: MISO is sampled on each SCK rising edge, MSB first. The byte is stored at buffer index base+count of the current receive descriptor.
- R4: When the final byte of a transmit buffer has been shifted out, that descriptor's ready bit (bit 31) clears and status bit 0 sets.
- R5: A transmit descriptor with last clear is followed by the next ready descriptor without a new start, with the same SCK rising-edge spacing across the buffer boundary.
- R6: A transmit descriptor with last set ends the transfer once its bytes are sent. cs_n_o stays low for the whole chained transfer and rises only after the final character.
- R7: A receive descriptor whose count reaches its length closes with empty (bit 31) cleared and status bit 1 set. Later bytes go to the next receive descriptor.
- R8: When transmission stops, a partly filled receive descriptor is closed and its length field is overwritten with the byte count received.
- R9: A character that arrives while the current receive descriptor is not empty is discarded. Status bit 2 sets and the transfer ends at once with cs_n_o high.
- R10: irq_o is high exactly when some status bit is set and its mask bit is set. Writing 1 to a status bit clears it.
- R11: A start while the current transmit descriptor is not ready, or has length 0, is ignored: cs_n_o stays high and no SCK edge occurs.
- R12: A descriptor with its wrap bit set is followed by entry 0 of its ring, for both transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Write space: 0 regs, 1 tx desc, 2 rx desc, 3 buffer |
| wr_addr_i | input | 8 | Write address within the space |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read space, same coding as wr_sel_i |
| rd_addr_i | input | 8 | Read address within the space |
| rd_data_o | output | 32 | Read data, combinational |
| sck_o | output | 1 | SPI clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Slave select, active low |
| irq_o | output | 1 | Maskable interrupt |

## Verification
The hardest state to reach is a buffer boundary in the middle of a transfer. Here the holding stage must already contain the next descriptor's first byte at the instant the current character ends, and at the same edge a receive descriptor may fill and a transmit descriptor may retire. The bench gets there by looping MOSI back inverted onto MISO and running a chained transfer at divider 0, where the gap between characters is shortest. It then sets receive lengths that differ from the transmit lengths, so that full, partial and wrapped receive closes all fall on character edges. Overrun is reached by leaving the next receive descriptor not empty with a known byte in its buffer, and then checking that the byte survives.

// File: rtl/spi_bd_pkg.sv
package spi_bd_pkg;
  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_TXD = 2'd1;
  localparam logic [1:0] SEL_RXD = 2'd2;
  localparam logic [1:0] SEL_BUF = 2'd3;

  typedef struct packed {
    logic        flag;   // tx: ready, rx: empty
    logic        wrap;
    logic        last;
    logic [15:0] len;
    logic [7:0]  base;
  } bd_t;

  function automatic bd_t bd_unpack(logic [31:0] w);
    bd_t b;
    b.flag = w[31];
    b.wrap = w[30];
    b.last = w[29];
    b.len  = w[23:8];
    b.base = w[7:0];
    return b;
  endfunction

  function automatic logic [31:0] bd_pack(bd_t b);
    return {b.flag, b.wrap, b.last, 5'b0, b.len, b.base};
  endfunction
endpackage

// File: rtl/spi_bd_shifter.sv
module spi_bd_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] div_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic [7:0] cnt_q, tx_q, rx_q;
  logic [2:0] bit_q;
  logic       sck_q, busy_q;
  logic       edge_w;

  assign edge_w = busy_q && (cnt_q == div_i);
  assign done_o = edge_w && sck_q && (bit_q == 3'd7);
  assign sck_o  = sck_q;
  assign mosi_o = busy_q & tx_q[7];
  assign busy_o = busy_q;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; tx_q <= '0; rx_q <= '0; bit_q <= '0;
      sck_q <= 1'b0; busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q <= 1'b1; tx_q <= byte_i; cnt_q <= '0; bit_q <= '0; sck_q <= 1'b0;
      end
    end else if (edge_w) begin
      cnt_q <= '0;
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[6:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        if (bit_q == 3'd7) begin
          if (load_i) begin
            tx_q <= byte_i; bit_q <= '0;  // back-to-back character
          end else begin
            busy_q <= 1'b0;
          end
        end else begin
          bit_q <= bit_q + 3'd1;
          tx_q  <= {tx_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_q <= cnt_q + 8'd1;
    end
  end
endmodule

// File: rtl/spi_bd_buf.sv
module spi_bd_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          sw_we_i,
  input  logic [AW-1:0] sw_addr_i,
  input  logic [7:0]    sw_data_i,
  input  logic          eng_we_i,
  input  logic [AW-1:0] eng_addr_i,
  input  logic [7:0]    eng_data_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [7:0]    rd_a_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [7:0]    rd_b_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (eng_we_i)     mem_q[eng_addr_i] <= eng_data_i;
    else if (sw_we_i) mem_q[sw_addr_i]  <= sw_data_i;
  end

  assign rd_a_o = mem_q[rd_a_addr_i];
  assign rd_b_o = mem_q[rd_b_addr_i];
endmodule

// File: rtl/spi_bd_master.sv
module spi_bd_master
  import spi_bd_pkg::*;
#(
  parameter int NTX       = 4,
  parameter int NRX       = 4,
  parameter int BUF_DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [7:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  input  logic [7:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_n_o,
  output logic        irq_o
);
  localparam int TXW = (NTX > 1) ? $clog2(NTX) : 1;
  localparam int RXW = (NRX > 1) ? $clog2(NRX) : 1;
  localparam int AW  = $clog2(BUF_DEPTH);

  bd_t txbd_q [NTX];
  bd_t rxbd_q [NRX];
  logic [7:0]     div_q, hold_q, tx_rd, sw_rd, rx_byte;
  logic [2:0]     mask_q, st_q, st_set;
  logic           active_q, tx_run_q, hold_v_q, hold_eob_q, cur_eob_q;
  logic [TXW-1:0] tx_idx_q, hold_bd_q, cur_bd_q;
  logic [RXW-1:0] rx_idx_q;
  logic [15:0]    tx_off_q, rx_cnt_q;
  bd_t            tx_cur, rx_cur;
  logic           sh_busy, sh_done, fetch_ok, fetch_now, fetch_end, start_go, ld;
  logic           ovr_now, stop_now, rx_we, rx_full, rx_part, tx_fin, reg_wr;
  logic [AW-1:0]  tx_addr, rx_addr;
  logic           unused_bits;

  function automatic logic [TXW-1:0] tx_next(logic [TXW-1:0] i, logic w);
    return (w || i == TXW'(NTX - 1)) ? '0 : i + TXW'(1);
  endfunction
  function automatic logic [RXW-1:0] rx_next(logic [RXW-1:0] i, logic w);
    return (w || i == RXW'(NRX - 1)) ? '0 : i + RXW'(1);
  endfunction

  assign tx_cur    = txbd_q[tx_idx_q];
  assign rx_cur    = rxbd_q[rx_idx_q];
  assign reg_wr    = wr_en_i && wr_sel_i == SEL_REG;
  assign start_go  = reg_wr && wr_addr_i == 8'd0 && wr_data_i[31] && !active_q &&
                     tx_cur.flag && tx_cur.len != 16'd0;
  assign fetch_ok  = tx_run_q && tx_cur.flag && tx_cur.len != 16'd0;
  assign fetch_now = active_q && fetch_ok && !hold_v_q;
  assign fetch_end = tx_off_q + 16'd1 == tx_cur.len;
  assign ovr_now   = sh_done && !rx_cur.flag;
  assign ld        = active_q && hold_v_q && (!sh_busy || sh_done) && !ovr_now;
  assign stop_now  = active_q && !hold_v_q && !sh_busy && !fetch_ok;
  assign rx_we     = sh_done && rx_cur.flag;
  assign rx_full   = rx_we && (rx_cnt_q + 16'd1 == rx_cur.len);
  assign rx_part   = stop_now && rx_cnt_q != 16'd0;
  assign tx_fin    = sh_done && cur_eob_q;
  assign tx_addr   = tx_cur.base[AW-1:0] + tx_off_q[AW-1:0];
  assign rx_addr   = rx_cur.base[AW-1:0] + rx_cnt_q[AW-1:0];
  assign st_set    = {ovr_now, rx_full | rx_part, tx_fin};
  assign cs_n_o    = ~active_q;
  assign irq_o     = |(st_q & mask_q);
  assign unused_bits = ^{wr_data_i[28:24], wr_addr_i, rd_addr_i};

  spi_bd_shifter u_shift (
    .clk_i, .rst_ni, .div_i(div_q), .load_i(ld), .byte_i(hold_q), .miso_i,
    .sck_o, .mosi_o, .busy_o(sh_busy), .done_o(sh_done), .rx_o(rx_byte)
  );

  spi_bd_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i,
    .sw_we_i(wr_en_i && wr_sel_i == SEL_BUF), .sw_addr_i(wr_addr_i[AW-1:0]),
    .sw_data_i(wr_data_i[7:0]),
    .eng_we_i(rx_we), .eng_addr_i(rx_addr), .eng_data_i(rx_byte),
    .rd_a_addr_i(tx_addr), .rd_a_o(tx_rd),
    .rd_b_addr_i(rd_addr_i[AW-1:0]), .rd_b_o(sw_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; mask_q <= '0; st_q <= '0;
      active_q <= 1'b0; tx_run_q <= 1'b0; tx_idx_q <= '0; tx_off_q <= '0;
      hold_v_q <= 1'b0; hold_q <= '0; hold_eob_q <= 1'b0; hold_bd_q <= '0;
      cur_eob_q <= 1'b0; cur_bd_q <= '0; rx_idx_q <= '0; rx_cnt_q <= '0;
    end else begin
      if (reg_wr && wr_addr_i == 8'd0) begin
        div_q <= wr_data_i[7:0]; mask_q <= wr_data_i[10:8];
      end
      if (reg_wr && wr_addr_i == 8'd1) st_q <= (st_q & ~wr_data_i[2:0]) | st_set;
      else                             st_q <= st_q | st_set;
      if (start_go) begin
        active_q <= 1'b1; tx_run_q <= 1'b1; tx_off_q <= '0;
      end
      if (fetch_now) begin
        hold_q <= tx_rd; hold_v_q <= 1'b1; hold_eob_q <= fetch_end; hold_bd_q <= tx_idx_q;
        if (fetch_end) begin
          tx_off_q <= '0;
          tx_idx_q <= tx_next(tx_idx_q, tx_cur.wrap);
          if (tx_cur.last) tx_run_q <= 1'b0;
        end else begin
          tx_off_q <= tx_off_q + 16'd1;
        end
      end
      if (ld) begin
        hold_v_q <= 1'b0; cur_eob_q <= hold_eob_q; cur_bd_q <= hold_bd_q;
      end
      if (rx_full || rx_part) begin
        rx_cnt_q <= '0; rx_idx_q <= rx_next(rx_idx_q, rx_cur.wrap);
      end else if (rx_we) begin
        rx_cnt_q <= rx_cnt_q + 16'd1;
      end
      if (stop_now) begin
        active_q <= 1'b0; tx_run_q <= 1'b0;
      end
      if (ovr_now) begin  // abort wins over everything above
        active_q <= 1'b0; tx_run_q <= 1'b0; hold_v_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NTX; i++) txbd_q[i] <= '0;
      for (int i = 0; i < NRX; i++) rxbd_q[i] <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_TXD) txbd_q[wr_addr_i[TXW-1:0]] <= bd_unpack(wr_data_i);
      if (wr_en_i && wr_sel_i == SEL_RXD) rxbd_q[wr_addr_i[RXW-1:0]] <= bd_unpack(wr_data_i);
      if (tx_fin) txbd_q[cur_bd_q].flag <= 1'b0;
      if (rx_full) rxbd_q[rx_idx_q].flag <= 1'b0;
      if (rx_part) begin
        rxbd_q[rx_idx_q].flag <= 1'b0;
        rxbd_q[rx_idx_q].len  <= rx_cnt_q;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_i)
      SEL_REG: rd_data_o = rd_addr_i[0] ? {28'b0, active_q, st_q} : {21'b0, mask_q, div_q};
      SEL_TXD: rd_data_o = bd_pack(txbd_q[rd_addr_i[TXW-1:0]]);
      SEL_RXD: rd_data_o = bd_pack(rxbd_q[rd_addr_i[RXW-1:0]]);
      default: rd_data_o = {24'b0, sw_rd};
    endcase
  end
endmodule

// File: rtl/spi_bd_master_chk.sv
module spi_bd_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       active_q,
  input logic       sh_busy,
  input logic       hold_v_q,
  input logic [2:0] st_q
);
  assert_sck_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);

  assert_mosi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_load_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_busy) |-> $past(hold_v_q));

  assert_sel_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> (!cs_n_o && active_q));

  assert_ovr_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q[2]) |-> cs_n_o);
endmodule

bind spi_bd_master spi_bd_master_chk u_chk (.*);

// File: tb/spi_bd_master_test.sv
module spi_bd_master_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic sck, mosi, miso, cs_n, irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign miso = ~mosi;  // inverted loopback

  spi_bd_master uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .irq_o(irq)
  );

  // line monitor, sampled on falling clock edge
  logic mon_clr = 0, sck_d = 0, cs_seen = 0;
  int cyc = 0, last_rise = 0, rises = 0, gmin = 0, gmax = 0, nb = 0;
  logic [7:0] sh = 0;
  logic [7:0] got [16];
  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      rises = 0; nb = 0; gmin = 1000; gmax = 0; cs_seen = 0;
    end else begin
      if (!cs_n) cs_seen = 1;
      if (sck && !sck_d) begin
        if (rises > 0) begin
          if (cyc - last_rise < gmin) gmin = cyc - last_rise;
          if (cyc - last_rise > gmax) gmax = cyc - last_rise;
        end
        last_rise = cyc;
        rises++;
        sh = {sh[6:0], mosi};
        if (rises % 8 == 0 && nb < 16) begin got[nb] = sh; nb++; end
      end
    end
    sck_d = sck;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] s, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_sel = s; rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] bd(bit f, bit w, bit l, int len, int base);
    return {f, w, l, 5'b0, 16'(len), 8'(base)};
  endfunction

  task automatic clr_mon();
    @(posedge clk); mon_clr = 1;
    @(posedge clk); mon_clr = 0;
  endtask

  task automatic run(logic [10:0] cfg);
    clr_mon();
    wr(2'd0, 8'd0, {1'b1, 20'b0, cfg});
    for (int i = 0; i < 50 && cs_n; i++) @(negedge clk);
    for (int i = 0; i < 5000 && !cs_n; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "cs_n", 32'(cs_n), 1); chk("R1", "sck", 32'(sck), 0);
    chk("R1", "mosi", 32'(mosi), 0); chk("R1", "irq", 32'(irq), 0);
    rd(2'd0, 8'd1, d); chk("R1", "status", d, 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    wr(2'd3, 8'd0, 32'hA5); wr(2'd3, 8'd1, 32'h3C);
    wr(2'd1, 8'd0, bd(1, 0, 1, 2, 0));
    wr(2'd2, 8'd0, bd(1, 0, 0, 4, 32));
    run({3'b000, 8'd1});
    chk("R2", "rises", rises, 16);
    chk("R2", "gap min", gmin, 4); chk("R2", "gap max", gmax, 4);
    chk("R2", "byte0", got[0], 8'hA5); chk("R2", "byte1", got[1], 8'h3C);
    rd(2'd3, 8'd32, d); chk("R3", "rx0", d, 8'h5A);
    rd(2'd3, 8'd33, d); chk("R3", "rx1", d, 8'hC3);
    rd(2'd1, 8'd0, d); chk("R4", "tx ready cleared", d, bd(0, 0, 1, 2, 0));
    rd(2'd2, 8'd0, d); chk("R8", "rx partial close", d, bd(0, 0, 0, 2, 32));
    rd(2'd0, 8'd1, d); chk("R4", "status", d, 32'h3);
    chk("R10", "masked irq", 32'(irq), 0);
    wr(2'd0, 8'd1, 32'h7);
    rd(2'd0, 8'd1, d); chk("R10", "w1c", d, 0);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    wr(2'd3, 8'd4, 32'h81); wr(2'd3, 8'd5, 32'h12); wr(2'd3, 8'd6, 32'h34);
    wr(2'd1, 8'd1, bd(1, 0, 0, 1, 4));
    wr(2'd1, 8'd2, bd(1, 0, 1, 2, 5));
    wr(2'd2, 8'd1, bd(1, 0, 0, 2, 40));
    wr(2'd2, 8'd2, bd(1, 0, 0, 4, 48));
    run({3'b000, 8'd0});
    chk("R5", "rises", rises, 24);
    chk("R5", "gap min", gmin, 2); chk("R5", "gap max", gmax, 2);
    chk("R5", "b0", got[0], 8'h81); chk("R5", "b1", got[1], 8'h12);
    chk("R6", "b2", got[2], 8'h34);
    chk("R6", "cs released", 32'(cs_n), 1);
    rd(2'd1, 8'd1, d); chk("R4", "txbd1", d, bd(0, 0, 0, 1, 4));
    rd(2'd1, 8'd2, d); chk("R4", "txbd2", d, bd(0, 0, 1, 2, 5));
    rd(2'd2, 8'd1, d); chk("R7", "rxbd1 full", d, bd(0, 0, 0, 2, 40));
    rd(2'd3, 8'd41, d); chk("R7", "rx 41", d, 8'hED);
    rd(2'd2, 8'd2, d); chk("R8", "rxbd2 partial", d, bd(0, 0, 0, 1, 48));
    rd(2'd3, 8'd48, d); chk("R7", "rx 48", d, 8'hCB);
    wr(2'd0, 8'd1, 32'h7);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(2'd3, 8'd8, 32'hF0); wr(2'd3, 8'd9, 32'h0F);
    wr(2'd1, 8'd3, bd(1, 1, 0, 1, 8));
    wr(2'd1, 8'd0, bd(1, 0, 1, 1, 9));
    wr(2'd2, 8'd3, bd(1, 1, 0, 1, 56));
    wr(2'd2, 8'd0, bd(1, 0, 0, 1, 57));
    run({3'b010, 8'd2});
    chk("R12", "tx wrap b0", got[0], 8'hF0); chk("R12", "tx wrap b1", got[1], 8'h0F);
    chk("R12", "bytes", nb, 2);
    rd(2'd3, 8'd56, d); chk("R12", "rx3", d, 8'h0F);
    rd(2'd3, 8'd57, d); chk("R12", "rx wrap to 0", d, 8'hF0);
    rd(2'd2, 8'd0, d); chk("R7", "rxbd0 closed", d, bd(0, 0, 0, 1, 57));
    chk("R10", "irq rx mask", 32'(irq), 1);
    wr(2'd0, 8'd1, 32'h2);
    chk("R10", "irq after w1c", 32'(irq), 0);
    wr(2'd0, 8'd1, 32'h7);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    wr(2'd3, 8'd10, 32'h99); wr(2'd3, 8'd11, 32'h66); wr(2'd3, 8'd60, 32'h55);
    wr(2'd1, 8'd1, bd(1, 0, 1, 2, 10));
    wr(2'd2, 8'd1, bd(0, 0, 0, 4, 60));
    run({3'b100, 8'd1});
    chk("R9", "rises", rises, 8);
    chk("R9", "cs high", 32'(cs_n), 1);
    rd(2'd3, 8'd60, d); chk("R9", "buffer kept", d, 8'h55);
    rd(2'd0, 8'd1, d); chk("R9", "status", d, 32'h4);
    chk("R10", "irq ovr", 32'(irq), 1);
    wr(2'd0, 8'd1, 32'h4);
    chk("R10", "irq cleared", 32'(irq), 0);
  endtask

  task automatic t_not_ready();
    wr(2'd1, 8'd1, bd(0, 0, 1, 2, 10));
    clr_mon();
    wr(2'd0, 8'd0, {1'b1, 20'b0, 11'd1});
    repeat (40) @(negedge clk);
    chk("R11", "cs never low", 32'(cs_seen), 0);
    chk("R11", "no sck", rises, 0);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_wrap();
    t_overrun();
    t_not_ready();
    finish_up();
  end
endmodule